// File: doc/BRIEF.md
# PLL Fast-Lock Timeout Controller

This block provides the digital control for the bandwidth-switching method of speeding up lock in a PLL synthesizer. Configuration arrives as 32-bit register writes. The block watches for the write that programs a new output frequency. If fast-lock is configured, that write opens a wide-band interval. During the interval the charge-pump current code is forced to its maximum, which gives sixteen times the programmed current, and the multiplexed output pin shorts the extra loop-filter resistor to ground.

The interval length is a 12-bit count of phase-detector cycles. Each cycle is marked by a one-clock `pfd_tick` strobe that arrives in the system clock domain. A 40 us interval at a 13 MHz comparison rate needs a count of 520. When the count runs out, the programmed current and the pin state both return in the same clock cycle. A `busy` output marks the interval. The analog charge pump, the loop filter and the VCO are outside this block.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `cp_code` is 0 and `mux_pull_low` is 0.
- R2: A write to address 0 starts an interval when the stored address-4 register has mode field [20:19] = 01 and timeout field [18:7] nonzero. On the next cycle `busy` is 1 and `cp_code` is 4'hF.
- R3: `busy` stays high until exactly N clock edges have seen both `busy` and `pfd_tick` high, where N is the timeout field. While `busy` is high, `cp_code` is 4'hF.
- R4: On the cycle `busy` falls, `cp_code` returns to the programmed code (address-2 bits [12:9]) and `mux_pull_low` returns to 0.
- R5: If the mode field is anything other than 01, a write to address 0 has no effect on `busy`, `cp_code` or `mux_pull_low`.
- R6: A timeout field of 0 produces no interval. `busy` stays 0 and `cp_code` keeps the programmed code.
- R7: `mux_pull_low` is 1 only while `busy` is 1 and the output-select field (address-0 bits [30:27]) is 4'b1100. Otherwise it is 0.
- R8: A write to address 0 during an interval reloads the count, so a full N further ticks follow that write.
- R9: Writes to addresses 2 or 4 during an interval do not shorten, extend or un-boost it. A new current code written during the interval appears only after expiry.
- R10: A `pfd_tick` in the same cycle as a starting or restarting write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pfd_tick | input | 1 | One-clock strobe per phase-detector cycle |
| cp_code | output | 4 | Charge-pump current code to the analog pump |
| mux_pull_low | output | 1 | Multiplexed pin shorted to ground |
| busy | output | 1 | Wide-band interval active |

## Verification
A restart write and a counting tick can land on the same clock edge. The same edge can also carry the last tick of an interval. The bench provokes both cases. It raises `pfd_tick` during an address-0 write partway through an interval, and it also restarts an interval on the cycle where its final count would have landed. Each case is judged by counting the qualifying ticks after the write and comparing that count with the loaded value. The comparison shows that the reload took priority and no tick was lost or double-counted.

// File: rtl/fl_pkg.sv
// Package: shared widths and register field positions for the fast-lock controller.
// Assumes the 32-bit register layout used by the frequency, current and timer registers.
package fl_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int CNT_W       = 12;
    localparam int CP_W        = 4;
    localparam int SEL_W       = 4;
    localparam int MODE_W      = 2;

    localparam logic [ADDR_W-1:0] A_FREQ  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CP    = 3'd2;
    localparam logic [ADDR_W-1:0] A_TIMER = 3'd4;

    localparam int LOAD_LSB = 7;
    localparam int MODE_LSB = 19;
    localparam int SEL_LSB  = 27;
    localparam int CP_LSB   = 9;

    localparam logic [MODE_W-1:0] MODE_FAST = 2'b01;
    localparam logic [SEL_W-1:0]  SEL_SWITCH = 4'b1100;
endpackage

// File: rtl/fl_regs.sv
// Module: holds the fields of the frequency, current and timer registers
// and flags a frequency write. Assumes one write per cycle at most.
module fl_regs
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              freq_wr,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] mode,
    output logic [CP_W-1:0]   cp_prog,
    output logic [SEL_W-1:0]  mux_sel
);
    // Capture register fields on their writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_val <= '0;
            mode     <= '0;
            cp_prog  <= '0;
            mux_sel  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_FREQ:  mux_sel <= wr_data[SEL_LSB +: SEL_W];
                A_CP:    cp_prog <= wr_data[CP_LSB +: CP_W];
                A_TIMER: begin
                    load_val <= wr_data[LOAD_LSB +: CNT_W];
                    mode     <= wr_data[MODE_LSB +: MODE_W];
                end
                default: ;
            endcase
        end
    end

    // Flag the write that programs a new frequency.
    always_comb freq_wr = wr_en && (wr_addr == A_FREQ);
endmodule

// File: rtl/fl_timer.sv
// Module: down-counter of PFD ticks that holds busy for exactly the loaded count.
// Assumes start already qualifies mode and a nonzero load; start beats a tick.
module fl_timer
    import fl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    // Load on start, count ticks while busy, drop busy after the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            busy   <= 1'b0;
        end else if (start) begin
            remain <= load_val;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/fl_drive.sv
// Module: output stage that boosts the current code and pulls the pin low
// during the interval. Assumes all-ones is the maximum current code.
module fl_drive
    import fl_pkg::*;
(
    input  logic             busy,
    input  logic [CP_W-1:0]  cp_prog,
    input  logic [SEL_W-1:0] mux_sel,
    output logic [CP_W-1:0]  cp_code,
    output logic             mux_pull_low
);
    localparam logic [CP_W-1:0] CP_MAX = '1;

    // Choose boosted or programmed current and gate the pin switch.
    always_comb begin
        cp_code      = busy ? CP_MAX : cp_prog;
        mux_pull_low = busy && (mux_sel == SEL_SWITCH);
    end
endmodule

// File: rtl/fastlock_ctrl.sv
// Module: fast-lock timeout controller top. A frequency write with fast-lock
// mode and a nonzero timeout opens a wide-band interval counted in PFD ticks.
// Assumes pfd_tick is a synchronous one-clock strobe.
module fastlock_ctrl
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pfd_tick,
    output logic [CP_W-1:0]   cp_code,
    output logic              mux_pull_low,
    output logic              busy
);
    logic              freq_wr;
    logic [CNT_W-1:0]  load_val;
    logic [MODE_W-1:0] mode;
    logic [CP_W-1:0]   cp_prog;
    logic [SEL_W-1:0]  mux_sel;
    logic              start;

    fl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freq_wr(freq_wr), .load_val(load_val),
        .mode(mode), .cp_prog(cp_prog), .mux_sel(mux_sel)
    );

    // Qualify a frequency write as the start of an interval.
    always_comb start = freq_wr && (mode == MODE_FAST) && (load_val != '0);

    fl_timer u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(pfd_tick),
        .load_val(load_val), .busy(busy)
    );

    fl_drive u_drive (
        .busy(busy), .cp_prog(cp_prog), .mux_sel(mux_sel),
        .cp_code(cp_code), .mux_pull_low(mux_pull_low)
    );
endmodule

// File: rtl/fastlock_ctrl_chk.sv
// Module: property checker for fastlock_ctrl, bound to every instance.
module fastlock_ctrl_chk
    import fl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CP_W-1:0]   cp_code,
    input logic              mux_pull_low,
    input logic              busy,
    input logic [CNT_W-1:0]  load_val,
    input logic [MODE_W-1:0] mode
);
    logic go;
    always_comb go = wr_en && (wr_addr == A_FREQ) && (mode == MODE_FAST) && (load_val != '0);

    assert_boost_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && (cp_code == '1)));
    assert_boost_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cp_code == '1));
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mux_pull_low);
    assert_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && (wr_addr == A_FREQ) && (mode != MODE_FAST)) |=> !busy);
    assert_zero_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && (wr_addr == A_FREQ) && (load_val == '0)) |=> !busy);
    assert_pin_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mux_pull_low |-> busy);
    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> busy);
endmodule

bind fastlock_ctrl fastlock_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cp_code(cp_code), .mux_pull_low(mux_pull_low), .busy(busy),
    .load_val(load_val), .mode(mode)
);

// File: tb/sim_fastlock_ctrl.sv
// Bench: sweeps timeout values, tick spacings and select codes, and counts
// qualifying ticks against the loaded value.
module sim_fastlock_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pfd_tick = 1'b0;
    logic [3:0]  cp_code;
    logic        mux_pull_low;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    fastlock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pfd_tick(pfd_tick), .cp_code(cp_code),
        .mux_pull_low(mux_pull_low), .busy(busy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] r4(input int n, input int md);
        return (32'(md) << 19) | (32'(n) << 7);
    endfunction

    // Write one register; returns 1 ns after the capturing edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit tk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; pfd_tick = tk;
        @(posedge clk); #1;
        wr_en = 1'b0; pfd_tick = 1'b0;
    endtask

    // Count qualifying ticks until busy falls; tick every p-th cycle.
    task automatic run_count(input int p, input int cp, input int sel, output int n);
        n = 0;
        for (int i = 0; i < 5000 && busy; i++) begin
            pfd_tick = ((i % p) == (p - 1));
            #3;
            if (busy && pfd_tick) n++;
            if (cp_code != 4'hF) chk(0, "R3", cp_code, 15);
            if (mux_pull_low != (sel == 12)) chk(0, "R7", mux_pull_low, sel == 12);
            @(posedge clk); #1;
        end
        pfd_tick = 1'b0;
        chk(cp_code == 4'(cp), "R4", cp_code, cp);
        chk(mux_pull_low == 1'b0, "R4", mux_pull_low, 0);
    endtask

    initial begin
        int n;
        #1;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; #2;
        chk(busy == 0, "R1", busy, 0);
        chk(cp_code == 0, "R1", cp_code, 0);
        chk(mux_pull_low == 0, "R1", mux_pull_low, 0);
        @(posedge clk); #1;

        // R2 R3 R4 R7: sweep timeout, tick spacing and select
        for (int p = 1; p <= 3; p++) begin
            for (int len = 1; len <= 24; len++) begin
                int sel = (len % 2) ? 12 : 5;
                int cp  = (len + p) % 15;
                wr(3'd2, 32'(cp) << 9, 0);
                wr(3'd4, r4(len, 1), 0);
                wr(3'd0, 32'(sel) << 27, 0);
                chk(busy == 1 && cp_code == 4'hF, "R2", cp_code, 15);
                run_count(p, cp, sel, n);
                chk(n == len, "R3", n, len);
            end
        end

        // R5: other modes never start
        for (int md = 0; md < 4; md++) begin
            if (md == 1) continue;
            wr(3'd2, 32'd6 << 9, 0);
            wr(3'd4, r4(9, md), 0);
            wr(3'd0, 32'd12 << 27, 0);
            #2;
            chk(busy == 0 && cp_code == 6 && mux_pull_low == 0, "R5", cp_code, 6);
            @(posedge clk); #1;
        end

        // R6: zero timeout
        wr(3'd4, r4(0, 1), 0);
        wr(3'd0, 32'd12 << 27, 0);
        #2;
        chk(busy == 0 && cp_code == 6 && mux_pull_low == 0, "R6", cp_code, 6);
        @(posedge clk); #1;

        // R8 R10: restart mid-interval with a coincident tick
        wr(3'd4, r4(20, 1), 0);
        wr(3'd0, 32'd12 << 27, 0);
        for (int i = 0; i < 7; i++) begin pfd_tick = 1; @(posedge clk); #1; end
        wr(3'd0, 32'd12 << 27, 1);
        chk(busy == 1, "R8", busy, 1);
        run_count(1, 6, 12, n);
        chk(n == 20, "R10", n, 20);

        // R8: restart exactly on the would-be final tick
        wr(3'd4, r4(4, 1), 0);
        wr(3'd0, 32'd12 << 27, 0);
        for (int i = 0; i < 3; i++) begin pfd_tick = 1; @(posedge clk); #1; end
        wr(3'd0, 32'd12 << 27, 1);
        chk(busy == 1, "R8", busy, 1);
        run_count(1, 6, 12, n);
        chk(n == 4, "R8", n, 4);

        // R9: current and timer writes mid-interval
        wr(3'd4, r4(10, 1), 0);
        wr(3'd0, 32'd12 << 27, 0);
        for (int i = 0; i < 3; i++) begin pfd_tick = 1; @(posedge clk); #1; end
        wr(3'd2, 32'd9 << 9, 0);
        chk(cp_code == 4'hF, "R9", cp_code, 15);
        wr(3'd4, r4(100, 1), 0);
        run_count(1, 9, 12, n);
        chk(n == 7, "R9", n, 7);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule